// File: doc/BRIEF.md
# Masked Associative Search Unit

This block is a small content-addressable store. Every stored word is compared in parallel against a search key. A per-bit mask chooses which bit positions take part in the compare. The per-word hits are ANDed with a candidate register, which holds one bit per word, and the result goes to a fixed-priority resolver. The resolver reports one winning word as a one-hot vector and as a binary index, with a valid flag.

Each search that finds a winner clears that word's candidate bit. When the same key and mask are strobed again, the next matching word in ascending index order comes out. The valid flag drops when no candidates that match are left. Software or a sequencer loads the candidate register before a new walk, either with all ones or with a chosen vector. Words are written one at a time through a simple write port.

Top module: `assoc_search_unit`

## Requirements
- R1: Bit b of a stored word takes part in the compare only when mask bit b is 1. A word matches when all of its participating bits equal the key. A mask of all zeros makes every word match.
- R2: A word whose candidate bit is 0 is never reported, whatever it holds. The qualified vector is the raw match vector ANDed with the candidate register (bit i belongs to word i).
- R3: When several qualified words match, the one with the lowest index wins. The one-hot output has at most one bit set.
- R4: A search that reports word i clears candidate bit i. Repeating the same search lists all qualified matches in ascending index order, one per strobe.
- R5: When the qualified vector is all zeros, a search gives valid 0, a one-hot vector of 0 and an index of 0.
- R6: The outputs are registered. They change at the clock edge that samples the search strobe and hold their value in every cycle without a strobe.
- R7: A load command sets the candidate register to all ones when the fill-all input is 1, and to the supplied vector otherwise. A load takes precedence over the clear from R4 in the same cycle. A search in that cycle still uses the candidate value from before the load.
- R8: A write requested in the same cycle as a search strobe is dropped. That search, and every later search, sees the old contents.
- R9: Synchronous reset clears all stored words to zero, sets every candidate bit to 1 and drives all outputs to zero.
- R10: When valid is 1, the index output is the binary position of the single bit set in the one-hot output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one stored word |
| wr_addr | input | IDX_W | Index of the word to write |
| wr_data | input | WORD_W | Data to write |
| search_key | input | WORD_W | Pattern to compare against |
| search_mask | input | WORD_W | 1 = bit position takes part in the compare |
| search | input | 1 | Search strobe, one cycle per search |
| sel_load | input | 1 | Load the candidate register |
| sel_all | input | 1 | With sel_load: fill the candidate register with ones |
| sel_vec | input | NUM_WORDS | With sel_load and not sel_all: candidate value to load |
| hit_onehot | output | NUM_WORDS | Winning word, one-hot |
| hit_idx | output | IDX_W | Winning word, binary index |
| hit_valid | output | 1 | A qualified match was found |

## Verification
The hardest states to reach from the ports are the edges of a walk. One is the strobe after the last match has been consumed, when valid must fall. The other is a cycle in which a load, a write and a search meet. The bench walks a table of load/search rows over four fixed words with overlapping matches, so walks run to exhaustion under full, partial and empty masks and under sparse candidate vectors. Directed steps then issue a load together with a search, and a write together with a search. Follow-up searches show which candidate value and which word contents took effect.

// File: rtl/assoc_pkg.sv
package assoc_pkg;
  localparam int DEF_NUM_WORDS = 4;
  localparam int DEF_WORD_W    = 4;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/assoc_store.sv
module assoc_store #(
  parameter int NUM_WORDS = assoc_pkg::DEF_NUM_WORDS,
  parameter int WORD_W    = assoc_pkg::DEF_WORD_W,
  localparam int IDX_W    = assoc_pkg::idx_width(NUM_WORDS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [IDX_W-1:0]            waddr,
  input  logic [WORD_W-1:0]           wdata,
  output logic [NUM_WORDS*WORD_W-1:0] words_flat
);
  logic [WORD_W-1:0] mem [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
    end else if (we && (int'(waddr) < NUM_WORDS)) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_flat
    assign words_flat[g*WORD_W +: WORD_W] = mem[g];
  end
endmodule

// File: rtl/assoc_match.sv
module assoc_match #(
  parameter int NUM_WORDS = assoc_pkg::DEF_NUM_WORDS,
  parameter int WORD_W    = assoc_pkg::DEF_WORD_W
) (
  input  logic [NUM_WORDS*WORD_W-1:0] words_flat,
  input  logic [WORD_W-1:0]           key,
  input  logic [WORD_W-1:0]           mask,
  output logic [NUM_WORDS-1:0]        raw_hit
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_cmp
    logic [WORD_W-1:0] diff;
    assign diff       = (words_flat[g*WORD_W +: WORD_W] ^ key) & mask;
    assign raw_hit[g] = (diff == '0);
  end
endmodule

// File: rtl/assoc_priority.sv
module assoc_priority #(
  parameter int NUM_WORDS = assoc_pkg::DEF_NUM_WORDS,
  localparam int IDX_W    = assoc_pkg::idx_width(NUM_WORDS)
) (
  input  logic [NUM_WORDS-1:0] req,
  output logic [NUM_WORDS-1:0] win_oh,
  output logic [IDX_W-1:0]     win_idx,
  output logic                 any
);
  logic [NUM_WORDS-1:0] lower_busy;

  assign lower_busy[0] = 1'b0;
  for (genvar g = 1; g < NUM_WORDS; g++) begin : g_chain
    assign lower_busy[g] = lower_busy[g-1] | req[g-1];
  end

  assign win_oh = req & ~lower_busy;
  assign any    = |req;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (win_oh[i]) win_idx = win_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/assoc_search_unit.sv
module assoc_search_unit #(
  parameter int NUM_WORDS = assoc_pkg::DEF_NUM_WORDS,
  parameter int WORD_W    = assoc_pkg::DEF_WORD_W,
  localparam int IDX_W    = assoc_pkg::idx_width(NUM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic [WORD_W-1:0]    search_key,
  input  logic [WORD_W-1:0]    search_mask,
  input  logic                 search,
  input  logic                 sel_load,
  input  logic                 sel_all,
  input  logic [NUM_WORDS-1:0] sel_vec,
  output logic [NUM_WORDS-1:0] hit_onehot,
  output logic [IDX_W-1:0]     hit_idx,
  output logic                 hit_valid
);
  logic [NUM_WORDS*WORD_W-1:0] words_flat;
  logic [NUM_WORDS-1:0]        raw_hit;
  logic [NUM_WORDS-1:0]        qual_hit;
  logic [NUM_WORDS-1:0]        cand_q;
  logic [NUM_WORDS-1:0]        win_oh;
  logic [IDX_W-1:0]            win_idx;
  logic                        win_any;
  logic                        store_we;

  // a write that collides with a search is dropped
  assign store_we = wr_en & ~search;

  assoc_store #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .we         (store_we),
    .waddr      (wr_addr),
    .wdata      (wr_data),
    .words_flat (words_flat)
  );

  assoc_match #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_match (
    .words_flat (words_flat),
    .key        (search_key),
    .mask       (search_mask),
    .raw_hit    (raw_hit)
  );

  assign qual_hit = raw_hit & cand_q;

  assoc_priority #(.NUM_WORDS(NUM_WORDS)) u_prio (
    .req     (qual_hit),
    .win_oh  (win_oh),
    .win_idx (win_idx),
    .any     (win_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= '1;
    end else if (sel_load) begin
      cand_q <= sel_all ? '1 : sel_vec;
    end else if (search) begin
      cand_q <= cand_q & ~win_oh;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_onehot <= '0;
      hit_idx    <= '0;
      hit_valid  <= 1'b0;
    end else if (search) begin
      hit_onehot <= win_oh;
      hit_idx    <= win_idx;
      hit_valid  <= win_any;
    end
  end
endmodule

// File: rtl/assoc_search_unit_chk.sv
module assoc_search_unit_chk #(
  parameter int NUM_WORDS = assoc_pkg::DEF_NUM_WORDS,
  localparam int IDX_W    = assoc_pkg::idx_width(NUM_WORDS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 search,
  input logic                 sel_load,
  input logic                 sel_all,
  input logic [NUM_WORDS-1:0] sel_vec,
  input logic [NUM_WORDS-1:0] cand_q,
  input logic [NUM_WORDS-1:0] hit_onehot,
  input logic [IDX_W-1:0]     hit_idx,
  input logic                 hit_valid
);
  assert_single_winner_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_onehot));

  assert_valid_has_winner_R3: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> $countones(hit_onehot) == 1);

  assert_empty_result_R5: assert property (@(posedge clk) disable iff (rst)
    !hit_valid |-> (hit_onehot == '0 && hit_idx == '0));

  assert_index_agrees_R10: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> hit_onehot[hit_idx]);

  assert_hold_without_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(search) && !$past(rst)) |-> ($stable(hit_onehot) && $stable(hit_idx) && $stable(hit_valid)));

  assert_winner_retired_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(search) && !$past(sel_load) && !$past(rst) && hit_valid) |-> ((cand_q & hit_onehot) == '0));

  assert_load_value_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(sel_load) && !$past(rst)) |-> (cand_q == ($past(sel_all) ? {NUM_WORDS{1'b1}} : $past(sel_vec))));

  assert_winner_was_candidate_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(search) && !$past(rst) && hit_valid) |-> (($past(cand_q) & hit_onehot) != '0));
endmodule

bind assoc_search_unit assoc_search_unit_chk #(.NUM_WORDS(NUM_WORDS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .search     (search),
  .sel_load   (sel_load),
  .sel_all    (sel_all),
  .sel_vec    (sel_vec),
  .cand_q     (cand_q),
  .hit_onehot (hit_onehot),
  .hit_idx    (hit_idx),
  .hit_valid  (hit_valid)
);

// File: tb/assoc_search_unit_test.sv
module assoc_search_unit_test;
  localparam int NW = 4;
  localparam int WW = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic [IW-1:0] wr_addr;
  logic [WW-1:0] wr_data;
  logic [WW-1:0] search_key;
  logic [WW-1:0] search_mask;
  logic          search;
  logic          sel_load;
  logic          sel_all;
  logic [NW-1:0] sel_vec;
  logic [NW-1:0] hit_onehot;
  logic [IW-1:0] hit_idx;
  logic          hit_valid;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  assoc_search_unit #(.NUM_WORDS(NW), .WORD_W(WW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .search_key(search_key), .search_mask(search_mask), .search(search),
    .sel_load(sel_load), .sel_all(sel_all), .sel_vec(sel_vec),
    .hit_onehot(hit_onehot), .hit_idx(hit_idx), .hit_valid(hit_valid)
  );

  // row: load(1) vec(4) key(4) mask(4) exp_oh(4) exp_idx(2) exp_valid(1)
  // stored words: w0=1010 w1=0011 w2=1011 w3=0011
  localparam logic [19:0] ROWS [12] = '{
    {1'b1, 4'b1111, 4'b0011, 4'b1111, 4'b0010, 2'd1, 1'b1},
    {1'b0, 4'b0000, 4'b0011, 4'b1111, 4'b1000, 2'd3, 1'b1},
    {1'b0, 4'b0000, 4'b0011, 4'b1111, 4'b0000, 2'd0, 1'b0},
    {1'b1, 4'b1111, 4'b0011, 4'b1100, 4'b0010, 2'd1, 1'b1},
    {1'b0, 4'b0000, 4'b0011, 4'b1100, 4'b1000, 2'd3, 1'b1},
    {1'b1, 4'b1111, 4'b1000, 4'b1000, 4'b0001, 2'd0, 1'b1},
    {1'b0, 4'b0000, 4'b1000, 4'b1000, 4'b0100, 2'd2, 1'b1},
    {1'b0, 4'b0000, 4'b1000, 4'b1000, 4'b0000, 2'd0, 1'b0},
    {1'b1, 4'b0110, 4'b0000, 4'b0000, 4'b0010, 2'd1, 1'b1},
    {1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0100, 2'd2, 1'b1},
    {1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd0, 1'b0},
    {1'b1, 4'b1000, 4'b0000, 4'b0000, 4'b1000, 2'd3, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_hit(input string req, input logic [NW-1:0] oh,
                           input logic [IW-1:0] idx, input logic v);
    check({req, " onehot"}, int'(hit_onehot), int'(oh));
    check({req, " index"},  int'(hit_idx),    int'(idx));
    check({req, " valid"},  int'(hit_valid),  int'(v));
  endtask

  task automatic write_word(input logic [IW-1:0] a, input logic [WW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_sel(input logic all, input logic [NW-1:0] v);
    sel_load = 1'b1; sel_all = all; sel_vec = v;
    @(negedge clk);
    sel_load = 1'b0; sel_all = 1'b0;
  endtask

  task automatic do_search(input logic [WW-1:0] k, input logic [WW-1:0] m);
    search = 1'b1; search_key = k; search_mask = m;
    @(negedge clk);
    search = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    search_key = '0; search_mask = '0; search = 1'b0;
    sel_load = 1'b0; sel_all = 1'b0; sel_vec = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: outputs zero after reset
    check_hit("R9 reset outputs", 4'b0000, 2'd0, 1'b0);
    // R9: storage zero and candidates all ones -> word 0 wins on key 0
    do_search(4'b0000, 4'b1111);
    check_hit("R9 reset storage", 4'b0001, 2'd0, 1'b1);

    write_word(2'd0, 4'b1010);
    write_word(2'd1, 4'b0011);
    write_word(2'd2, 4'b1011);
    write_word(2'd3, 4'b0011);

    // table walk: R1 masks, R2 candidates, R3 priority, R4 walk, R5 exhaustion
    for (int r = 0; r < 12; r++) begin
      if (ROWS[r][19]) load_sel(1'b0, ROWS[r][18:15]);
      do_search(ROWS[r][14:11], ROWS[r][10:7]);
      check_hit($sformatf("R1 R2 R3 R4 R5 row %0d", r),
                ROWS[r][6:3], ROWS[r][2:1], ROWS[r][0]);
    end

    // R6: outputs hold across idle cycles
    repeat (3) @(negedge clk);
    check_hit("R6 hold", 4'b1000, 2'd3, 1'b1);

    // R7: fill-all load
    load_sel(1'b1, 4'b0000);
    do_search(4'b0011, 4'b1111);
    check_hit("R7 fill all", 4'b0010, 2'd1, 1'b1);

    // R7: load with search in the same cycle; search sees candidates 1101
    sel_load = 1'b1; sel_all = 1'b1;
    do_search(4'b0011, 4'b1111);
    sel_load = 1'b0; sel_all = 1'b0;
    check_hit("R7 load with search old value", 4'b1000, 2'd3, 1'b1);
    do_search(4'b0011, 4'b1111);
    check_hit("R7 load beats clear", 4'b0010, 2'd1, 1'b1);

    // R8: write colliding with a search is dropped
    load_sel(1'b1, 4'b0000);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 4'b0101;
    do_search(4'b1010, 4'b1111);
    wr_en = 1'b0;
    check_hit("R8 search sees old word", 4'b0001, 2'd0, 1'b1);
    load_sel(1'b1, 4'b0000);
    do_search(4'b0101, 4'b1111);
    check_hit("R8 write dropped", 4'b0000, 2'd0, 1'b0);
    do_search(4'b1010, 4'b1111);
    check_hit("R8 old word kept", 4'b0001, 2'd0, 1'b1);

    // normal write takes effect (R8 contrast)
    write_word(2'd0, 4'b0111);
    load_sel(1'b1, 4'b0000);
    do_search(4'b0111, 4'b1111);
    check_hit("R8 plain write", 4'b0001, 2'd0, 1'b1);

    // R10 on a high index, R2 with a candidate excluded
    load_sel(1'b0, 4'b0100);
    do_search(4'b1011, 4'b1111);
    check_hit("R10 R2 word 2", 4'b0100, 2'd2, 1'b1);

    // R9: reset mid-walk
    load_sel(1'b0, 4'b0000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_hit("R9 reset mid-walk", 4'b0000, 2'd0, 1'b0);
    do_search(4'b0000, 4'b0000);
    check_hit("R9 candidates refilled", 4'b0001, 2'd0, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule